// File: doc/BRIEF.md
# Nibble-Stream Raster Pixel Formatter

This block turns a decoded stream of 4-bit codes, read back from one rotating disk track, into raster signals for a small colour LCD. One track holds a whole frame, and the frame repeats once per revolution. The refresh rate therefore follows the spindle: 300 RPM gives 5 frames per second. There is no free-running timing generator. Each accepted code is one pixel slot. Codes 0 to 7 are 3-bit RGB colours. The top code ends a line. The drive's once-per-revolution index pulse starts a new frame.

The formatter tracks the column and line position from these markers. It raises data-enable only for colour codes that fall inside the visible area, which defaults to 240 pixels by 160 lines. Every output is registered, and each one reflects the code accepted on the clock edge before.

Top module: `nibble_raster_fmt`

## Requirements
- R1: After synchronous reset, pix_ce, rgb, hsync, vsync and de are all 0.
- R2: An accepted code in the range 0..7 produces pix_ce = 1 and rgb equal to that code (bit 2 red, bit 1 green, bit 0 blue) on the cycle after acceptance. Any cycle without an accepted colour code gives pix_ce = 0 and rgb = 0.
- R3: de is 1 only for a colour code accepted while the column is below H_ACTIVE and the line is below V_ACTIVE. Each colour code advances the column by one, and the column saturates at H_ACTIVE.
- R4: Codes 8..14 give a blank slot: pix_ce = 0, de = 0 and rgb = 0, with the column left unchanged.
- R5: Code 15 gives hsync = 1 for exactly one cycle and returns the column to 0. It also advances the line by one, and the line saturates at V_ACTIVE.
- R6: A rising edge on index_in gives vsync = 1 for exactly one cycle and returns the line to 0. Holding index_in high produces no further vsync.
- R7: From reset until the first index rising edge, the line counts as outside the visible area, so de stays 0.
- R8: When an index rising edge and code 15 are accepted in the same cycle, the line becomes 0. Both hsync and vsync pulse.
- R9: Every output changes exactly one clock after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_valid | input | 1 | Accept strobe for nib_data |
| nib_data | input | NIB_W | Decoded code from the track |
| index_in | input | 1 | Drive index pulse, synchronous level |
| pix_ce | output | 1 | Pixel clock enable, one per colour code |
| rgb | output | PIX_W | Pixel colour |
| hsync | output | 1 | Line sync pulse |
| vsync | output | 1 | Frame sync pulse |
| de | output | 1 | Data enable for visible pixels |

## Verification
The bench builds the formatter with H_ACTIVE = 8 and V_ACTIVE = 4. At those values, column saturation and line saturation each take only a handful of codes to reach, instead of hundreds. The full code width and the sync code 15 are kept, so every code class is exercised. The sequences include rows that run past the right edge, frames with more lines than are visible, colour codes sent before any index pulse, an index held high, and an index edge that coincides with a line marker.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_COLOUR = 2'd1,
    K_BLANK  = 2'd2,
    K_HSYNC  = 2'd3
  } nib_kind_e;
endpackage

// File: rtl/nrf_classify.sv
module nrf_classify
  import nrf_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int PIX_W      = 3,
  parameter int HSYNC_CODE = 15
) (
  input  logic             valid,
  input  logic [NIB_W-1:0] code,
  output nib_kind_e        kind
);
  localparam logic [NIB_W-1:0] HS_CODE = NIB_W'(HSYNC_CODE);

  always_comb begin
    if (!valid)                         kind = K_NONE;
    else if (code[NIB_W-1:PIX_W] == '0) kind = K_COLOUR;
    else if (code == HS_CODE)           kind = K_HSYNC;
    else                                kind = K_BLANK;
  end
endmodule

// File: rtl/nrf_edge.sv
module nrf_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/nrf_raster.sv
module nrf_raster
  import nrf_pkg::*;
#(
  parameter int H_ACTIVE = 240,
  parameter int V_ACTIVE = 160,
  localparam int COL_W = $clog2(H_ACTIVE + 1),
  localparam int LIN_W = $clog2(V_ACTIVE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  nib_kind_e        kind,
  input  logic             frame_start,
  output logic [COL_W-1:0] col,
  output logic [LIN_W-1:0] line,
  output logic             in_area
);
  localparam logic [COL_W-1:0] H_LIM = COL_W'(H_ACTIVE);
  localparam logic [LIN_W-1:0] V_LIM = LIN_W'(V_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      line <= V_LIM;
    end else begin
      if (kind == K_HSYNC)
        col <= '0;
      else if (kind == K_COLOUR && col != H_LIM)
        col <= col + 1'b1;

      if (frame_start)
        line <= '0;
      else if (kind == K_HSYNC && line != V_LIM)
        line <= line + 1'b1;
    end
  end

  assign in_area = (col < H_LIM) && (line < V_LIM);

  // R5
  col_home_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == K_HSYNC) |=> (col == '0));
  // R6
  line_home_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (line == '0));
  // R3
  col_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (col == H_LIM && kind != K_HSYNC) |=> (col == H_LIM));
endmodule

// File: rtl/nibble_raster_fmt.sv
module nibble_raster_fmt
  import nrf_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int PIX_W      = 3,
  parameter int HSYNC_CODE = 15,
  parameter int H_ACTIVE   = 240,
  parameter int V_ACTIVE   = 160
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_valid,
  input  logic [NIB_W-1:0] nib_data,
  input  logic             index_in,
  output logic             pix_ce,
  output logic [PIX_W-1:0] rgb,
  output logic             hsync,
  output logic             vsync,
  output logic             de
);
  localparam int COL_W = $clog2(H_ACTIVE + 1);
  localparam int LIN_W = $clog2(V_ACTIVE + 1);

  nib_kind_e        kind;
  logic             frame_start;
  logic             in_area;
  logic [COL_W-1:0] col;
  logic [LIN_W-1:0] line;

  nrf_classify #(.NIB_W(NIB_W), .PIX_W(PIX_W), .HSYNC_CODE(HSYNC_CODE)) u_cls (
    .valid(nib_valid), .code(nib_data), .kind(kind)
  );

  nrf_edge u_idx (
    .clk(clk), .rst(rst), .level_in(index_in), .rise(frame_start)
  );

  nrf_raster #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_pos (
    .clk(clk), .rst(rst), .kind(kind), .frame_start(frame_start),
    .col(col), .line(line), .in_area(in_area)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_ce <= 1'b0;
      rgb    <= '0;
      hsync  <= 1'b0;
      vsync  <= 1'b0;
      de     <= 1'b0;
    end else begin
      pix_ce <= (kind == K_COLOUR);
      rgb    <= (kind == K_COLOUR) ? nib_data[PIX_W-1:0] : '0;
      hsync  <= (kind == K_HSYNC);
      vsync  <= frame_start;
      de     <= (kind == K_COLOUR) && in_area;
    end
  end

  // R4
  de_needs_pce_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> pix_ce);
  // R5
  hsync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hsync |-> (!pix_ce && !de && rgb == '0));
  // R6
  vsync_single_chk: assert property (@(posedge clk) disable iff (rst)
    vsync |=> !vsync);
  // R9
  colour_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (nib_valid && nib_data[NIB_W-1:PIX_W] == '0) |=> (pix_ce && rgb == $past(nib_data[PIX_W-1:0])));
endmodule

// File: tb/tb_nibble_raster_fmt.sv
module tb_nibble_raster_fmt;
  localparam int HA = 8;
  localparam int VA = 4;

  typedef struct packed {
    logic       pce;
    logic [2:0] rgb;
    logic       hs;
    logic       vs;
    logic       de;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nib_valid = 1'b0;
  logic [3:0] nib_data = '0;
  logic index_in = 1'b0;
  logic pix_ce, hsync, vsync, de;
  logic [2:0] rgb;

  int compared = 0;
  int mismatched = 0;
  exp_t q[$];

  int m_col = 0;
  int m_line = VA;
  logic m_idx = 1'b0;

  always #4 clk = ~clk;

  nibble_raster_fmt #(.H_ACTIVE(HA), .V_ACTIVE(VA)) dut (
    .clk(clk), .rst(rst), .nib_valid(nib_valid), .nib_data(nib_data),
    .index_in(index_in), .pix_ce(pix_ce), .rgb(rgb), .hsync(hsync),
    .vsync(vsync), .de(de)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one slot and pushes the expected registered result (R9).
  task automatic step(input logic v, input logic [3:0] d, input logic idx);
    exp_t e;
    logic colour, hs, rise;
    @(negedge clk);
    nib_valid = v; nib_data = d; index_in = idx;
    colour = v && d < 4'd8;
    hs     = v && d == 4'd15;
    rise   = idx && !m_idx;
    e.pce = colour;                              // R2
    e.rgb = colour ? d[2:0] : 3'd0;              // R2, R4
    e.hs  = hs;                                  // R5
    e.vs  = rise;                                // R6
    e.de  = colour && m_col < HA && m_line < VA; // R3, R7
    q.push_back(e);
    if (hs) m_col = 0;
    else if (colour && m_col < HA) m_col++;
    if (rise) m_line = 0;                        // R8: index wins
    else if (hs && m_line < VA) m_line++;
    m_idx = idx;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2 pix_ce", int'(pix_ce), int'(e.pce));
        chk("R2 rgb",    int'(rgb),    int'(e.rgb));
        chk("R5 hsync",  int'(hsync),  int'(e.hs));
        chk("R6 vsync",  int'(vsync),  int'(e.vs));
        chk("R3 de",     int'(de),     int'(e.de));
      end
    end
  end

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pix_ce", int'(pix_ce), 0);
    chk("R1 rgb",    int'(rgb),    0);
    chk("R1 hsync",  int'(hsync),  0);
    chk("R1 vsync",  int'(vsync),  0);
    chk("R1 de",     int'(de),     0);

    // R7: colour before any index -> de low
    for (int i = 0; i < 3; i++) step(1'b1, 4'(i + 1), 1'b0);
    step(1'b1, 4'd15, 1'b0);
    // R6: index rise, then held high
    step(1'b0, 4'd0, 1'b1);
    step(1'b0, 4'd0, 1'b1);
    step(1'b0, 4'd0, 1'b1);
    // R3: row longer than HA, saturating column
    for (int i = 0; i < HA + 3; i++) step(1'b1, 4'(i % 8), 1'b1);
    // R5: line end
    step(1'b1, 4'd15, 1'b0);
    // R4: blanks interleaved, column untouched
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 4'(8 + i), 1'b0);
      step(1'b1, 4'(7 - i), 1'b0);
      step(1'b0, 4'd3, 1'b0);
    end
    // R5: more lines than visible, line saturates
    for (int l = 0; l < VA + 2; l++) begin
      for (int i = 0; i < 3; i++) step(1'b1, 4'(l + i), 1'b0);
      step(1'b1, 4'd15, 1'b0);
    end
    // R8: index edge together with hsync
    step(1'b1, 4'd15, 1'b1);
    for (int i = 0; i < HA; i++) step(1'b1, 4'd5, 1'b1);
    step(1'b1, 4'd15, 1'b0);
    step(1'b1, 4'd2, 1'b0);
    step(1'b1, 4'd6, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 4'd0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule